// File: doc/BRIEF.md
# Read-Sequence Write-Protect Detector

This block watches the stream of read cycles on a byte-wide memory bus. It keeps a single write-protect flag for the command sequencer that sits beside it. The flag comes up set. A fixed run of seven reads at chosen addresses clears it. A second run, which differs only in its last address, sets it again. The words carried on the data pins play no part, so the block takes no data input at all.

Each read cycle reaches the block as a one-clock strobe, `rd_stb`. The address on `rd_addr` is the value the bus front end latched at the earlier of the output-enable and chip-enable rising edges. A write cycle on the same bus reaches the block as the strobe `wr_stb`. The block follows the position reached in the sequence. A read that breaks the sequence, or any write, throws that progress away. A run only takes effect when its seventh read arrives.

Top module: `rdseq_unlock_detector`

## Requirements
- R1: During reset and on the first cycle after it, `wp_flag` reads 1 (protected).
- R2: Seven consecutive read strobes at 01823h, 01820h, 01822h, 00418h, 0041Bh, 00419h, 0041Ah drive `wp_flag` to 0. The change is visible one clock after the seventh strobe.
- R3: The same first six reads followed by a seventh at 0040Ah drive `wp_flag` to 1, one clock after the seventh strobe.
- R4: A read whose address is not the next expected entry (and is not 01823h) discards all progress, so the whole seven-read run must start again.
- R5: A mismatching read at 01823h is taken as the first read of a new run.
- R6: A write strobe anywhere inside a run discards all progress.
- R7: `wp_flag` holds its value on every cycle except the one after a completed run. Idle cycles between the reads of a run neither break it nor change the flag.
- R8: A completed clearing run while already cleared leaves `wp_flag` at 0. A completed setting run while already set leaves it at 1.
- R9: Matching uses all 19 address bits, so for example 4041Ah as the seventh read completes nothing.
- R10: When a read strobe and a write strobe arrive in the same cycle, the write wins and the read is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | One-cycle pulse per completed read cycle |
| rd_addr | input | 19 | Latched address of the read, valid with `rd_stb` |
| wr_stb | input | 1 | One-cycle pulse per write cycle on the bus |
| wp_flag | output | 1 | Registered write-protect flag, 1 = protected |

## Verification
The main function is driven with both complete runs in each flag state. This separates a real state change from a flag that simply toggles or only ever moves one way. Runs broken by a stray address, by a repeated head address, by a write, and by a coinciding read and write are then followed by the intended tail address. This shows whether the step counter really restarted, as opposed to skipping the bad read. A tail with a high address bit set, and a run spread out with idle gaps, show whether the full address width is compared and whether only strobed cycles advance the match.

// File: rtl/rsu_pkg.sv
`timescale 1ns/1ps
package rsu_pkg;
  localparam int RSU_ADDR_W  = 19;
  localparam int RSU_SEQ_LEN = 7;
  localparam int RSU_STEP_W  = $clog2(RSU_SEQ_LEN);

  // Tail address that clears protection and tail address that sets it.
  localparam logic [RSU_ADDR_W-1:0] RSU_TAIL_OPEN  = 19'h0041A;
  localparam logic [RSU_ADDR_W-1:0] RSU_TAIL_CLOSE = 19'h0040A;

  // Shared head of both runs; the order is the behaviour.
  function automatic logic [RSU_ADDR_W-1:0] rsu_head_entry(input int unsigned idx);
    case (idx)
      0:       return 19'h01823;
      1:       return 19'h01820;
      2:       return 19'h01822;
      3:       return 19'h00418;
      4:       return 19'h0041B;
      5:       return 19'h00419;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/rsu_addr_match.sv
`timescale 1ns/1ps
module rsu_addr_match
  import rsu_pkg::*;
#(
  parameter int ADDR_W  = RSU_ADDR_W,
  parameter int SEQ_LEN = RSU_SEQ_LEN,
  parameter int STEP_W  = RSU_STEP_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [STEP_W-1:0] step,
  output logic              hit_next,
  output logic              hit_head,
  output logic              hit_open,
  output logic              hit_close
);
  localparam int HEAD_N = SEQ_LEN - 1;
  localparam logic [STEP_W-1:0] LAST = STEP_W'(HEAD_N);

  logic [SEQ_LEN-1:0] match;

  // One comparator per shared head entry.
  for (genvar i = 0; i < HEAD_N; i++) begin : g_cmp
    assign match[i] = (addr == ADDR_W'(rsu_head_entry(i)));
  end
  assign match[SEQ_LEN-1] = 1'b0;

  assign hit_next  = (step < LAST) ? match[step] : 1'b0;
  assign hit_head  = match[0];
  assign hit_open  = (addr == ADDR_W'(RSU_TAIL_OPEN));
  assign hit_close = (addr == ADDR_W'(RSU_TAIL_CLOSE));
endmodule

// File: rtl/rsu_step_track.sv
`timescale 1ns/1ps
module rsu_step_track
  import rsu_pkg::*;
#(
  parameter int SEQ_LEN = RSU_SEQ_LEN,
  parameter int STEP_W  = RSU_STEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic              hit_next,
  input  logic              hit_head,
  input  logic              hit_open,
  input  logic              hit_close,
  output logic [STEP_W-1:0] step,
  output logic              set_open,
  output logic              set_close
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(SEQ_LEN - 1);

  logic [STEP_W-1:0] step_d;

  always_comb begin
    step_d    = step;
    set_open  = 1'b0;
    set_close = 1'b0;
    if (wr_stb) begin
      step_d = '0;
    end else if (rd_stb) begin
      if (step == LAST) begin
        set_open  = hit_open;
        set_close = hit_close & ~hit_open;
        step_d    = hit_head ? STEP_W'(1) : '0;
      end else if (hit_next) begin
        step_d = step + STEP_W'(1);
      end else begin
        step_d = hit_head ? STEP_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step <= '0;
    else     step <= step_d;
  end

  p_wr_abort_r6: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> (step == '0));
  p_head_restart_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !wr_stb && hit_head) |=> (step == STEP_W'(1)));
  p_miss_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !wr_stb && !hit_next && !hit_head && step != LAST) |=> (step == '0));
  p_step_bound_r7: assert property (@(posedge clk) disable iff (rst)
    step <= LAST);
endmodule

// File: rtl/rsu_prot_flag.sv
`timescale 1ns/1ps
module rsu_prot_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_open,
  input  logic set_close,
  output logic wp_flag
);
  always_ff @(posedge clk) begin
    if (rst)            wp_flag <= 1'b1;
    else if (set_open)  wp_flag <= 1'b0;
    else if (set_close) wp_flag <= 1'b1;
  end

  p_one_cmd_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({set_open, set_close}));
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!set_open && !set_close) |=> $stable(wp_flag));
  p_open_r2: assert property (@(posedge clk) disable iff (rst)
    set_open |=> !wp_flag);
  p_close_r3: assert property (@(posedge clk) disable iff (rst)
    set_close |=> wp_flag);
endmodule

// File: rtl/rdseq_unlock_detector.sv
`timescale 1ns/1ps
module rdseq_unlock_detector
  import rsu_pkg::*;
#(
  parameter int ADDR_W  = RSU_ADDR_W,
  parameter int SEQ_LEN = RSU_SEQ_LEN,
  parameter int STEP_W  = RSU_STEP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_stb,
  output logic              wp_flag
);
  logic [STEP_W-1:0] step;
  logic hit_next, hit_head, hit_open, hit_close;
  logic set_open, set_close;

  rsu_addr_match #(.ADDR_W(ADDR_W), .SEQ_LEN(SEQ_LEN), .STEP_W(STEP_W)) u_match (
    .addr(rd_addr), .step(step), .hit_next(hit_next), .hit_head(hit_head),
    .hit_open(hit_open), .hit_close(hit_close)
  );

  rsu_step_track #(.SEQ_LEN(SEQ_LEN), .STEP_W(STEP_W)) u_track (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .hit_next(hit_next), .hit_head(hit_head), .hit_open(hit_open),
    .hit_close(hit_close), .step(step), .set_open(set_open), .set_close(set_close)
  );

  rsu_prot_flag u_flag (
    .clk(clk), .rst(rst), .set_open(set_open), .set_close(set_close), .wp_flag(wp_flag)
  );

  p_reset_prot_r1: assert property (@(posedge clk) rst |=> wp_flag);
  p_wr_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && wr_stb) |=> $stable(wp_flag));
endmodule

// File: tb/rdseq_unlock_detector_bench.sv
`timescale 1ns/1ps
module rdseq_unlock_detector_bench;
  logic clk = 1'b0;
  logic rst, rd_stb, wr_stb, wp_flag;
  logic [18:0] rd_addr;
  int cyc = 0, nchk = 0, nfail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rdseq_unlock_detector u_rdseq_unlock_detector (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .wr_stb(wr_stb), .wp_flag(wp_flag)
  );

  typedef struct { bit exp; int due; string tag; } item_t;
  item_t q[$];
  item_t it;

  // Monitor: compare every item whose clock edge has passed.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      it = q.pop_front();
      nchk++;
      if (wp_flag !== it.exp) begin
        nfail++;
        $display("FAIL %s: wp_flag=%0b expected %0b", it.tag, wp_flag, it.exp);
      end
    end
  end

  task automatic drive(bit rd, bit wr, logic [18:0] a, bit exp, string tag);
    @(negedge clk);
    rd_stb = rd; wr_stb = wr; rd_addr = a;
    q.push_back('{exp, cyc + 1, tag});
  endtask
  task automatic rd(logic [18:0] a, bit exp, string tag); drive(1, 0, a, exp, tag); endtask
  task automatic idle(bit exp, string tag); drive(0, 0, '0, exp, tag); endtask
  task automatic head6(bit e, string tag);
    rd(19'h01823, e, tag); rd(19'h01820, e, tag); rd(19'h01822, e, tag);
    rd(19'h00418, e, tag); rd(19'h0041B, e, tag); rd(19'h00419, e, tag);
  endtask

  initial begin
    rst = 1; rd_stb = 0; wr_stb = 0; rd_addr = '0;
    repeat (3) @(negedge clk);
    nchk++;
    if (wp_flag !== 1'b1) begin nfail++; $display("FAIL R1: wp_flag=%0b expected 1", wp_flag); end
    rst = 0;
    idle(1, "R1");
    // R2: clearing run
    head6(1, "R2"); rd(19'h0041A, 0, "R2"); idle(0, "R2");
    // R8: clearing again while clear
    head6(0, "R8"); rd(19'h0041A, 0, "R8");
    // R3: setting run
    head6(0, "R3"); rd(19'h0040A, 1, "R3"); idle(1, "R3");
    // R8: setting again while set
    head6(1, "R8"); rd(19'h0040A, 1, "R8");
    // R4: stray address mid-run, then the rest of the run
    rd(19'h01823, 1, "R4"); rd(19'h01820, 1, "R4"); rd(19'h01822, 1, "R4");
    rd(19'h00418, 1, "R4"); rd(19'h00000, 1, "R4"); rd(19'h0041B, 1, "R4");
    rd(19'h00419, 1, "R4"); rd(19'h0041A, 1, "R4");
    // R5: repeated head restarts at step one
    rd(19'h01823, 1, "R5"); rd(19'h01820, 1, "R5"); rd(19'h01823, 1, "R5");
    rd(19'h01820, 1, "R5"); rd(19'h01822, 1, "R5"); rd(19'h00418, 1, "R5");
    rd(19'h0041B, 1, "R5"); rd(19'h00419, 1, "R5"); rd(19'h0041A, 0, "R5");
    head6(0, "R3"); rd(19'h0040A, 1, "R3");
    // R6: write in the middle aborts
    head6(1, "R6"); drive(0, 1, 19'h0041A, 1, "R6"); rd(19'h0041A, 1, "R6");
    // R9: high address bit set on tail and on head
    head6(1, "R9"); rd(19'h4041A, 1, "R9");
    rd(19'h41823, 1, "R9"); rd(19'h01820, 1, "R9"); rd(19'h01822, 1, "R9");
    rd(19'h00418, 1, "R9"); rd(19'h0041B, 1, "R9"); rd(19'h00419, 1, "R9");
    rd(19'h0041A, 1, "R9");
    // R10: read and write together, write wins, run is lost
    head6(1, "R10"); drive(1, 1, 19'h0041A, 1, "R10"); rd(19'h0041A, 1, "R10");
    // R7: run spread out with idle gaps; flag holds during gaps
    rd(19'h01823, 1, "R7"); idle(1, "R7"); rd(19'h01820, 1, "R7"); idle(1, "R7");
    idle(1, "R7"); rd(19'h01822, 1, "R7"); rd(19'h00418, 1, "R7"); idle(1, "R7");
    rd(19'h0041B, 1, "R7"); rd(19'h00419, 1, "R7"); idle(1, "R7");
    rd(19'h0041A, 0, "R7"); idle(0, "R7"); idle(0, "R7");
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nfail++;
      $display("FAIL R7 watchdog: run not complete, actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule